// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a parameterised chain of boundary scan cells that sits between the core logic and the device pads. Three kinds of cell are provided. Input cells sit on pad-to-core signals. Output cells sit on core-to-pad data. Control cells sit on core-to-pad output enables, and each control cell gates a fixed-size group of output cells. Every cell has a serial stage clocked on the rising test clock and a parallel hold stage loaded on the falling test clock. The shift stages together form one serial path from `scanIn` to `scanOut`.

A TAP controller, which lives outside this block, drives the block. It supplies state strobes for capture, shift and update, a chain-select, a test-mode flag, a force-tristate flag and an active-low test-logic reset. In normal mode the core and the pads see each other directly. In test mode the pads and the core inputs are fed from the hold stages. The force-tristate flag turns every pad enable off in either mode. This lets the controller float the outputs, or park them at held values, while a different register is on the scan path.

Top module: `bscan_chain`

## Requirements
- R1: While `tapResetN` is low, the shift and hold stages are 0 and the block acts in normal mode whatever `testMode` says. After release in test mode, `pinOut`, `pinOe`, `coreIn` and `scanOut` are all 0.
- R2: With `testMode` low, `pinOut` equals `coreOut`, `coreIn` equals `pinIn`, and `pinOe` equals `coreOe` unless R8 applies.
- R3: The shift stage uses this cell order, counted from `scanOut`. Cells 0..NUM_IN-1 are input cells (cell i on `pinIn[i]`). The next NUM_GRP cells are control cells (`coreOe[g]`). The last NUM_GRP*GRP_SIZE cells are output cells (`coreOut[j]`). On a rising `tck` with `captureDr` and `chainSel` high, each cell loads its own signal.
- R4: On a rising `tck` with `shiftDr` and `chainSel` high, every cell takes the value of its neighbour one position further from `scanOut`. The last cell takes `scanIn`, and `scanOut` always shows cell 0.
- R5: On a falling `tck` with `updateDr` and `chainSel` high, the hold stage copies the shift stage. The hold stage does not change before that falling edge.
- R6: Without an update, the hold stage keeps its value, so pins driven from it stay still during capture and shift.
- R7: With `testMode` high, `pinOut[j]`, `pinOe[g]` and `coreIn[i]` show the hold values of their own cells. `pinOe[g]` is the enable for `pinOut[g*GRP_SIZE +: GRP_SIZE]`.
- R8: With `forceTristate` high, `pinOe` is all zeros in either mode, and `pinOut` is unaffected.
- R9: With `chainSel` low, capture, shift and update strobes have no effect on the shift or hold stages.
- R10: If `captureDr` and `shiftDr` are both high, capture wins. Update acts only when neither is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tapResetN | input | 1 | Test-logic reset, active low, asynchronous |
| captureDr | input | 1 | Controller is in the capture state |
| shiftDr | input | 1 | Controller is in the shift state |
| updateDr | input | 1 | Controller is in the update state |
| chainSel | input | 1 | This chain is the selected data register |
| testMode | input | 1 | Drive pads and core inputs from the hold stages |
| forceTristate | input | 1 | Force all pad enables off |
| scanIn | input | 1 | Serial data from the controller |
| scanOut | output | 1 | Serial data to the controller (cell 0) |
| pinIn | input | NUM_IN | Values arriving from input pads |
| coreIn | output | NUM_IN | Input values presented to the core |
| coreOut | input | NUM_GRP*GRP_SIZE | Output data from the core |
| coreOe | input | NUM_GRP | Output enables from the core, one per group |
| pinOut | output | NUM_GRP*GRP_SIZE | Output data to the pads |
| pinOe | output | NUM_GRP | Output enables to the pads, one per group |

## Verification
The assertions check several rules on every rising edge. The strobes are mutually exclusive and stay silent when the chain is deselected. A capture loads the exact pad and core vector, and a shift moves the chain by one cell. The hold stage never moves without an update, the force-tristate flag always clears the pad enables, and normal mode passes core and pad values straight through. Other behaviours can only be shown by the bench's scenarios: the serial order as seen end to end at `scanOut`, the update landing on the falling edge and not before, the full normal-mode sweep, and the reset override of test mode.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  // Strobes from the control module to the cell datapath.
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } scanStb_t;

  // Pin multiplexer controls.
  typedef struct packed {
    logic useHold;
    logic forceOff;
  } pinMode_t;

endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic     tck,
  input  logic     rstN,
  input  logic     captureDr,
  input  logic     shiftDr,
  input  logic     updateDr,
  input  logic     chainSel,
  input  logic     testMode,
  input  logic     forceTristate,
  output scanStb_t stb,
  output pinMode_t mode
);

  // Capture outranks shift; update acts only when neither is present.
  always_comb begin
    stb.capture = chainSel & captureDr;
    stb.shift   = chainSel & shiftDr & ~captureDr;
    stb.update  = chainSel & updateDr & ~captureDr & ~shiftDr;
  end

  // Reset forces normal mode at once, without waiting for a clock.
  always_comb begin
    mode.useHold  = testMode & rstN;
    mode.forceOff = forceTristate;
  end

  // R10: at most one strobe reaches the datapath
  p_one_strobe_r10: assert property (@(posedge tck) disable iff (!rstN)
    $onehot0(stb));

  // R9: a deselected chain sees no strobe
  p_unselected_quiet_r9: assert property (@(posedge tck) disable iff (!rstN)
    !chainSel |-> (stb == '0));

endmodule

// File: rtl/bscan_path.sv
module bscan_path
  import bscan_pkg::*;
#(
  parameter int NUM_IN   = 3,
  parameter int NUM_GRP  = 2,
  parameter int GRP_SIZE = 2
) (
  input  logic                       tck,
  input  logic                       rstN,
  input  scanStb_t                   stb,
  input  logic                       scanIn,
  input  logic [NUM_IN-1:0]          pinIn,
  input  logic [NUM_GRP-1:0]         coreOe,
  input  logic [NUM_GRP*GRP_SIZE-1:0] coreOut,
  output logic                       scanOut,
  output logic [NUM_IN-1:0]          holdIn,
  output logic [NUM_GRP-1:0]         holdOe,
  output logic [NUM_GRP*GRP_SIZE-1:0] holdOut
);

  localparam int NUM_OUT  = NUM_GRP * GRP_SIZE;
  localparam int CTL_BASE = NUM_IN;
  localparam int OUT_BASE = NUM_IN + NUM_GRP;
  localparam int LEN      = NUM_IN + NUM_GRP + NUM_OUT;

  logic [LEN-1:0] capVec;
  logic [LEN-1:0] shiftQ;
  logic [LEN-1:0] holdQ;

  // Order from scanOut: input cells, control cells, output cells.
  assign capVec = {coreOut, coreOe, pinIn};

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    logic serIn;
    logic shBit;
    logic hdBit;

    if (i == LEN - 1) begin : g_head
      assign serIn = scanIn;
    end else begin : g_body
      assign serIn = shiftQ[i+1];
    end

    // Serial stage on the rising test clock.
    always_ff @(posedge tck or negedge rstN) begin
      if (!rstN)            shBit <= 1'b0;
      else if (stb.capture) shBit <= capVec[i];
      else if (stb.shift)   shBit <= serIn;
    end

    // Parallel hold stage on the falling test clock.
    always_ff @(negedge tck or negedge rstN) begin
      if (!rstN)           hdBit <= 1'b0;
      else if (stb.update) hdBit <= shBit;
    end

    assign shiftQ[i] = shBit;
    assign holdQ[i]  = hdBit;
  end

  assign scanOut = shiftQ[0];
  assign holdIn  = holdQ[CTL_BASE-1:0];
  assign holdOe  = holdQ[OUT_BASE-1:CTL_BASE];
  assign holdOut = holdQ[LEN-1:OUT_BASE];

  // R3: a capture loads the whole pad/core vector
  p_capture_load_r3: assert property (@(posedge tck) disable iff (!rstN)
    stb.capture |=> (shiftQ == $past(capVec)));

  // R4: a shift moves every cell one place toward scanOut
  p_shift_step_r4: assert property (@(posedge tck) disable iff (!rstN)
    stb.shift |=> (shiftQ[LEN-2:0] == $past(shiftQ[LEN-1:1])));

  // R6: the hold stage does not move without an update
  p_hold_stable_r6: assert property (@(posedge tck) disable iff (!rstN)
    !stb.update |-> $stable(holdQ));

endmodule

// File: rtl/bscan_pinmux.sv
module bscan_pinmux
  import bscan_pkg::*;
#(
  parameter int NUM_IN   = 3,
  parameter int NUM_GRP  = 2,
  parameter int GRP_SIZE = 2
) (
  input  logic                        tck,
  input  logic                        rstN,
  input  pinMode_t                    mode,
  input  logic [NUM_IN-1:0]           pinIn,
  input  logic [NUM_GRP*GRP_SIZE-1:0] coreOut,
  input  logic [NUM_GRP-1:0]          coreOe,
  input  logic [NUM_IN-1:0]           holdIn,
  input  logic [NUM_GRP*GRP_SIZE-1:0] holdOut,
  input  logic [NUM_GRP-1:0]          holdOe,
  output logic [NUM_IN-1:0]           coreIn,
  output logic [NUM_GRP*GRP_SIZE-1:0] pinOut,
  output logic [NUM_GRP-1:0]          pinOe
);

  assign coreIn = mode.useHold ? holdIn : pinIn;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign pinOut[g*GRP_SIZE +: GRP_SIZE] = mode.useHold ?
      holdOut[g*GRP_SIZE +: GRP_SIZE] : coreOut[g*GRP_SIZE +: GRP_SIZE];
    assign pinOe[g] = ~mode.forceOff & (mode.useHold ? holdOe[g] : coreOe[g]);
  end

  // R8: forced tristate clears every pad enable
  p_tristate_all_r8: assert property (@(posedge tck) disable iff (!rstN)
    mode.forceOff |-> (pinOe == '0));

  // R2: normal mode connects core and pads straight through
  p_normal_pass_r2: assert property (@(posedge tck) disable iff (!rstN)
    !mode.useHold |-> (pinOut == coreOut && coreIn == pinIn));

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int NUM_IN   = 3,
  parameter int NUM_GRP  = 2,
  parameter int GRP_SIZE = 2
) (
  input  logic                        tck,
  input  logic                        tapResetN,
  input  logic                        captureDr,
  input  logic                        shiftDr,
  input  logic                        updateDr,
  input  logic                        chainSel,
  input  logic                        testMode,
  input  logic                        forceTristate,
  input  logic                        scanIn,
  output logic                        scanOut,
  input  logic [NUM_IN-1:0]           pinIn,
  output logic [NUM_IN-1:0]           coreIn,
  input  logic [NUM_GRP*GRP_SIZE-1:0] coreOut,
  input  logic [NUM_GRP-1:0]          coreOe,
  output logic [NUM_GRP*GRP_SIZE-1:0] pinOut,
  output logic [NUM_GRP-1:0]          pinOe
);

  localparam int NUM_OUT = NUM_GRP * GRP_SIZE;

  scanStb_t            stb;
  pinMode_t            mode;
  logic [NUM_IN-1:0]   holdIn;
  logic [NUM_GRP-1:0]  holdOe;
  logic [NUM_OUT-1:0]  holdOut;

  bscan_ctrl u_ctrl (
    .tck           (tck),
    .rstN          (tapResetN),
    .captureDr     (captureDr),
    .shiftDr       (shiftDr),
    .updateDr      (updateDr),
    .chainSel      (chainSel),
    .testMode      (testMode),
    .forceTristate (forceTristate),
    .stb           (stb),
    .mode          (mode)
  );

  bscan_path #(.NUM_IN(NUM_IN), .NUM_GRP(NUM_GRP), .GRP_SIZE(GRP_SIZE)) u_path (
    .tck     (tck),
    .rstN    (tapResetN),
    .stb     (stb),
    .scanIn  (scanIn),
    .pinIn   (pinIn),
    .coreOe  (coreOe),
    .coreOut (coreOut),
    .scanOut (scanOut),
    .holdIn  (holdIn),
    .holdOe  (holdOe),
    .holdOut (holdOut)
  );

  bscan_pinmux #(.NUM_IN(NUM_IN), .NUM_GRP(NUM_GRP), .GRP_SIZE(GRP_SIZE)) u_pinmux (
    .tck     (tck),
    .rstN    (tapResetN),
    .mode    (mode),
    .pinIn   (pinIn),
    .coreOut (coreOut),
    .coreOe  (coreOe),
    .holdIn  (holdIn),
    .holdOut (holdOut),
    .holdOe  (holdOe),
    .coreIn  (coreIn),
    .pinOut  (pinOut),
    .pinOe   (pinOe)
  );

endmodule

// File: tb/tb_bscan_chain.sv
module tb_bscan_chain;

  localparam int NI  = 3;
  localparam int NG  = 2;
  localparam int GS  = 2;
  localparam int NO  = NG * GS;
  localparam int LEN = NI + NG + NO;

  logic          tck = 1'b0;
  logic          tapResetN;
  logic          captureDr, shiftDr, updateDr, chainSel;
  logic          testMode, forceTristate, scanIn;
  logic          scanOut;
  logic [NI-1:0] pinIn, coreIn;
  logic [NO-1:0] coreOut, pinOut;
  logic [NG-1:0] coreOe, pinOe;

  int checks = 0;
  int failures = 0;

  always #10 tck = ~tck;  // 50 MHz

  bscan_chain #(.NUM_IN(NI), .NUM_GRP(NG), .GRP_SIZE(GS)) dut (
    .tck(tck), .tapResetN(tapResetN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .chainSel(chainSel), .testMode(testMode),
    .forceTristate(forceTristate), .scanIn(scanIn), .scanOut(scanOut),
    .pinIn(pinIn), .coreIn(coreIn), .coreOut(coreOut), .coreOe(coreOe),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Move to 2 ns after the next rising edge.
  task automatic tick();
    @(posedge tck);
    #2;
  endtask

  // Check the pads and core inputs against a 9-bit hold image.
  task automatic chkHold(input string req, input logic [LEN-1:0] h, input logic ft);
    chk({req, " pinOut"}, 16'(pinOut), 16'(h[LEN-1:NI+NG]));
    chk({req, " pinOe"},  16'(pinOe),  ft ? 16'd0 : 16'(h[NI+NG-1:NI]));
    chk({req, " coreIn"}, 16'(coreIn), 16'(h[NI-1:0]));
  endtask

  // Shift LEN bits out and compare each with the expected vector.
  task automatic shiftOutChk(input string req, input logic [LEN-1:0] exp);
    chainSel = 1'b1;
    shiftDr  = 1'b1;
    scanIn   = 1'b0;
    for (int k = 0; k < LEN; k++) begin
      chk(req, 16'(scanOut), 16'(exp[k]));
      tick();
    end
    shiftDr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [LEN-1:0] held;
    logic [LEN-1:0] cap;

    tapResetN = 1'b0; captureDr = 1'b0; shiftDr = 1'b0; updateDr = 1'b0;
    chainSel = 1'b0; testMode = 1'b1; forceTristate = 1'b0; scanIn = 1'b0;
    pinIn = 3'b101; coreOut = 4'b1010; coreOe = 2'b11;
    held = '0;

    // R1: reset overrides test mode; core drives pads
    #5;
    chk("R1 reset pinOut follows core", 16'(pinOut), 16'hA);
    chk("R1 reset pinOe follows core",  16'(pinOe),  16'h3);
    chk("R1 reset scanOut",             16'(scanOut), 16'h0);
    tick(); tick();
    tapResetN = 1'b1;
    #1;
    chkHold("R1 after reset test mode", '0, 1'b0);
    chk("R1 after reset scanOut", 16'(scanOut), 16'h0);
    tick();

    // R2, R8: exhaustive normal-mode sweep
    testMode = 1'b0;
    for (int v = 0; v < 512; v++) begin
      for (int ft = 0; ft < 2; ft++) begin
        logic [8:0] w;
        w = 9'(v);
        coreOut = w[3:0]; coreOe = w[5:4]; pinIn = w[8:6];
        forceTristate = ft[0];
        #1;
        chk("R2 normal pinOut", 16'(pinOut), 16'(w[3:0]));
        chk("R2 normal coreIn", 16'(coreIn), 16'(w[8:6]));
        chk("R8/R2 normal pinOe", 16'(pinOe), ft[0] ? 16'd0 : 16'(w[5:4]));
      end
    end
    forceTristate = 1'b0;
    tick();

    // R3, R4: capture then shift out for several pad/core patterns
    for (int p = 0; p < 8; p++) begin
      pinIn   = 3'(p);
      coreOe  = 2'((p * 3) & 3);
      coreOut = 4'((p * 5 + 3) & 15);
      cap = {coreOut, coreOe, pinIn};
      chainSel = 1'b1; captureDr = 1'b1;
      tick();
      captureDr = 1'b0;
      pinIn = ~pinIn; coreOut = ~coreOut; coreOe = ~coreOe;
      shiftOutChk("R3/R4 capture order", cap);
    end

    // R4, R5, R6, R7, R8: shift in, update on falling edge, drive pins
    testMode = 1'b1;
    for (int n = 0; n < 24; n++) begin
      logic [LEN-1:0] w;
      w = 9'((n * 37 + 11) % 512);
      chainSel = 1'b1; shiftDr = 1'b1;
      for (int k = 0; k < LEN; k++) begin
        scanIn = w[k];
        tick();
        chk("R6 pins still during shift", 16'(pinOut), 16'(held[LEN-1:NI+NG]));
      end
      shiftDr = 1'b0; scanIn = 1'b0;
      updateDr = 1'b1;
      #3;
      chkHold("R5 before falling edge", held, 1'b0);
      @(negedge tck);
      #1;
      chkHold("R5/R7 after falling edge", w, 1'b0);
      @(posedge tck);
      #2;
      updateDr = 1'b0;
      held = w;
      forceTristate = 1'b1;
      #1;
      chkHold("R8 test mode tristate", held, 1'b1);
      forceTristate = 1'b0;
      tick();
    end

    // R9: deselected chain ignores every strobe
    chainSel = 1'b0;
    pinIn = 3'b010; coreOut = 4'b0110; coreOe = 2'b10;
    captureDr = 1'b1; tick(); captureDr = 1'b0;
    shiftDr = 1'b1; scanIn = 1'b1; tick(); tick(); tick(); shiftDr = 1'b0;
    updateDr = 1'b1; tick(); updateDr = 1'b0;
    tick();
    chkHold("R9 hold untouched", held, 1'b0);
    shiftOutChk("R9 shift stage untouched", held);

    // R10: capture wins over a simultaneous shift
    pinIn = 3'b110; coreOe = 2'b01; coreOut = 4'b1001;
    cap = {coreOut, coreOe, pinIn};
    chainSel = 1'b1; captureDr = 1'b1; shiftDr = 1'b1; scanIn = 1'b1;
    tick();
    captureDr = 1'b0; shiftDr = 1'b0; scanIn = 1'b0;
    shiftOutChk("R10 capture priority", cap);

    // R1: reset in the middle of test mode
    testMode = 1'b1;
    coreOut = 4'b0101; coreOe = 2'b01; pinIn = 3'b011;
    tapResetN = 1'b0;
    #1;
    chk("R1 mid reset pinOut", 16'(pinOut), 16'h5);
    chk("R1 mid reset coreIn", 16'(coreIn), 16'h3);
    tick();
    tapResetN = 1'b1;
    #1;
    chkHold("R1 hold cleared", '0, 1'b0);
    chk("R1 shift cleared", 16'(scanOut), 16'h0);
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule